// File: doc/BRIEF.md
# FM Synth Host Port Front-End

This block sits between a host I/O bus and an FM synthesis register file. The host writes a register index to an even port offset and a value to an odd offset. The block latches the indices, decides where each value goes, and emits one register write per cycle on a 9-bit downstream write port. The three timer registers are the exception: their writes go to a separate timer write port. Status reads are answered from two timer status bytes and from the control extension's own registers.

There are four operating modes, selected by `mode_sel` and held steady after reset:
- `0`: single 8-bit-index chip.
- `1`: wide chip with a 9-bit index. Offset bit 1 supplies index bit 8.
- `2`: paired chips. Port offset bit 3 broadcasts a write to both sides, and bit 1 otherwise picks one side. Values are rewritten so that the pair behaves like two narrow chips.
- `3`: wide chip plus a small control extension. Magic values written to address offset 2 open and close a control window, which holds two volume registers and a few identification bytes.

Top module: `fm_port_frontend`

## Requirements
- R1: While reset is asserted, no downstream or timer write is issued. After reset, both volume outputs hold 0xFF and the control window is closed.
- R2: In mode 0, a write to an even offset latches the 8-bit index, with bit 8 forced to 0. The next odd-offset write appears on the downstream port one cycle later, carrying that index and the value unchanged.
- R3: In modes 1 and 3, host offset bit 1 becomes bit 8 of the latched 9-bit index. Any index other than 0x002 to 0x004, including 0x105, is forwarded unchanged.
- R4: Data writes whose full index is 0x002, 0x003 or 0x004 go only to the timer write port. That port carries the side (0 outside mode 2), the low index byte and the value. Downstream valid and timer valid are never high together.
- R5: In mode 2 with offset bit 3 clear, offset bit 1 selects side 0 or side 1. Each side keeps its own 8-bit index. A side-1 write appears downstream at index plus 0x100.
- R6: In mode 2 with offset bit 3 set, an address write latches both side indices. A data write emits the side-0 write one cycle after the host write and the side-1 write one cycle after that.
- R7: In mode 2, writes to index 5 are dropped on both output ports. Values written to index 0xE0 or above keep only their low 2 bits.
- R8: In mode 2, values written to indices 0xC0 to 0xC8 keep their low nibble. The high nibble is forced to 0x5 on side 0 and 0xA on side 1. Index 0xC9 is not rewritten.
- R9: The first clock cycle after reset release ignores host writes. In mode 2, that cycle issues the downstream write 0x105 = 0x01.
- R10: In mode 3, writing 0xFF to offset 2 opens the control window and writing 0xFE closes it. While the window is open, any other value written to offset 2 sets the control index, and offset-3 data writes go to the control extension. None of these writes alters the chip index or reaches an output port.
- R11: In mode 3 with the window open, offset 2 reads 0x00 and offset 3 reads by control index: 0x00 gives 0x70, 0x09 gives the left volume, 0x0A gives the right volume, 0x15 gives 0x71, and any other index gives 0xFF.
- R12: A control data write with index 0x09 sets `vol_left` and one with index 0x0A sets `vol_right`. Control data writes to other indices change neither volume.
- R13: Reads outside the control window:
  - Mode 0: offset with low bits 00 returns status 0 OR 0x06. Any other offset returns 0xFF.
  - Modes 1 and 3: offset with low bits 00 returns status 0. Any other offset returns 0xFF.
  - Mode 2: an odd offset returns 0xFF. An even offset returns the status of the side given by bit 1, OR 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Operating mode, steady after reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_ofs | input | 4 | Host port offset for reads and writes |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for `host_ofs` (combinational) |
| tmr_stat0 | input | 8 | Timer status of side 0 |
| tmr_stat1 | input | 8 | Timer status of side 1 |
| dn_wr_valid | output | 1 | Downstream register write strobe |
| dn_wr_addr | output | 9 | Downstream register index |
| dn_wr_data | output | 8 | Downstream register value |
| tmr_wr_valid | output | 1 | Timer register write strobe |
| tmr_wr_side | output | 1 | Timer block side |
| tmr_wr_reg | output | 8 | Timer register index |
| tmr_wr_data | output | 8 | Timer register value |
| vol_left | output | 8 | Left volume register |
| vol_right | output | 8 | Right volume register |

## Verification
The checks assume that `mode_sel` does not change between resets. They also assume that a broadcast data write in mode 2 is followed by at least one idle cycle, because the second side borrows the output slot of the following cycle. The directed bench changes mode only under reset. Every host access lasts one cycle, and after each broadcast data write the bench spends a cycle observing the second side before it issues the next access. The bench issues exactly one host write during the ignored first cycle after reset, to check that it is dropped, and leaves that cycle idle everywhere else.

// File: rtl/fm_fe_pkg.sv
package fm_fe_pkg;
  localparam int IDX_W = 8;
  localparam int ADR_W = IDX_W + 1;
  localparam int OFS_W = 4;

  localparam logic [ADR_W-1:0] PAIR_INIT_ADR = 9'h105;
  localparam logic [IDX_W-1:0] PAIR_INIT_VAL = 8'h01;
  localparam logic [OFS_W-1:0] CTL_ADR_OFS   = 4'h2;
  localparam logic [OFS_W-1:0] CTL_DAT_OFS   = 4'h3;
  localparam logic [IDX_W-1:0] CTL_OPEN      = 8'hFF;
  localparam logic [IDX_W-1:0] CTL_CLOSE     = 8'hFE;
  localparam logic [IDX_W-1:0] VOL_L_IDX     = 8'h09;
  localparam logic [IDX_W-1:0] VOL_R_IDX     = 8'h0A;

  typedef enum logic [1:0] {
    FM_SINGLE   = 2'd0,
    FM_WIDE     = 2'd1,
    FM_PAIR     = 2'd2,
    FM_WIDE_CTL = 2'd3
  } fm_mode_e;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_CHIP  = 2'd1,
    SLOT_TIMER = 2'd2
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e       kind;
    logic             side;
    logic [ADR_W-1:0] addr;
    logic [IDX_W-1:0] val;
  } slot_t;

  localparam slot_t SLOT_NONE = '{kind: SLOT_IDLE, side: 1'b0, addr: '0, val: '0};

  function automatic logic is_timer_idx(input logic [ADR_W-1:0] a);
    return (a >= 9'h002) && (a <= 9'h004);
  endfunction

  // Wide or single chip: forward unchanged unless it is a timer register.
  function automatic slot_t plain_slot(input logic [ADR_W-1:0] a, input logic [IDX_W-1:0] v);
    slot_t s;
    s.kind = is_timer_idx(a) ? SLOT_TIMER : SLOT_CHIP;
    s.side = 1'b0;
    s.addr = a;
    s.val  = v;
    return s;
  endfunction

  // Paired chips: drop mode register, narrow waveform values, force pan bits.
  function automatic slot_t pair_slot(input logic side, input logic [IDX_W-1:0] r,
                                      input logic [IDX_W-1:0] v);
    slot_t s;
    s.kind = SLOT_CHIP;
    s.side = side;
    s.addr = {side, r};
    s.val  = v;
    if (r == 8'h05) begin
      s.kind = SLOT_IDLE;
    end else if (r >= 8'hE0) begin
      s.val = {6'b0, v[1:0]};
    end else if (is_timer_idx({1'b0, r})) begin
      s.kind = SLOT_TIMER;
    end else if (r >= 8'hC0 && r <= 8'hC8) begin
      s.val = {(side ? 4'hA : 4'h5), v[3:0]};
    end
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] ctl_read(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] vl,
                                                input logic [IDX_W-1:0] vr);
    case (idx)
      8'h00:     return 8'h70;
      VOL_L_IDX: return vl;
      VOL_R_IDX: return vr;
      8'h15:     return 8'h71;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] host_read(input fm_mode_e m,
                                                 input logic [OFS_W-1:0] ofs,
                                                 input logic ctl_on,
                                                 input logic [IDX_W-1:0] ctl_val,
                                                 input logic [IDX_W-1:0] s0,
                                                 input logic [IDX_W-1:0] s1);
    if (m == FM_WIDE_CTL && ctl_on && ofs == CTL_ADR_OFS) return 8'h00;
    if (m == FM_WIDE_CTL && ctl_on && ofs == CTL_DAT_OFS) return ctl_val;
    case (m)
      FM_SINGLE: return (ofs[1:0] == 2'b00) ? (s0 | 8'h06) : 8'hFF;
      FM_PAIR:   return ofs[0] ? 8'hFF : ((ofs[1] ? s1 : s0) | 8'h06);
      default:   return (ofs[1:0] == 2'b00) ? s0 : 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/fm_fe_ctrl.sv
module fm_fe_ctrl
  import fm_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [IDX_W-1:0] wdata,
  output logic             active,
  output logic             claim,
  output logic [IDX_W-1:0] vol_l,
  output logic [IDX_W-1:0] vol_r,
  output logic [IDX_W-1:0] rd_val
);
  logic [IDX_W-1:0] idx_q;
  logic at_idx, at_dat, is_open, is_close;

  assign at_idx   = (ofs == CTL_ADR_OFS);
  assign at_dat   = (ofs == CTL_DAT_OFS);
  assign is_open  = (wdata == CTL_OPEN);
  assign is_close = (wdata == CTL_CLOSE);
  assign claim    = enable && wr &&
                    ((at_idx && (is_open || is_close || active)) || (at_dat && active));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
      vol_l  <= 8'hFF;
      vol_r  <= 8'hFF;
    end else if (claim) begin
      if (at_idx) begin
        if (is_open)       active <= 1'b1;
        else if (is_close) active <= 1'b0;
        else               idx_q  <= wdata;
      end else begin
        if (idx_q == VOL_L_IDX)      vol_l <= wdata;
        else if (idx_q == VOL_R_IDX) vol_r <= wdata;
      end
    end
  end

  assign rd_val = ctl_read(idx_q, vol_l, vol_r);
endmodule

// File: rtl/fm_fe_index.sv
module fm_fe_index
  import fm_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fm_mode_e         mode,
  input  logic             addr_ev,
  input  logic             bank_bit,
  input  logic             both_bit,
  input  logic [IDX_W-1:0] wdata,
  output logic [ADR_W-1:0] norm_idx,
  output logic [IDX_W-1:0] side_idx [2]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      norm_idx    <= '0;
      side_idx[0] <= '0;
      side_idx[1] <= '0;
    end else if (addr_ev) begin
      case (mode)
        FM_SINGLE: norm_idx <= {1'b0, wdata};
        FM_PAIR: begin
          if (both_bit || !bank_bit) side_idx[0] <= wdata;
          if (both_bit ||  bank_bit) side_idx[1] <= wdata;
        end
        default:   norm_idx <= {bank_bit, wdata};
      endcase
    end
  end
endmodule

// File: rtl/fm_fe_route.sv
module fm_fe_route
  import fm_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fm_mode_e         mode,
  input  logic             init_fire,
  input  logic             data_ev,
  input  logic             bank_bit,
  input  logic             both_bit,
  input  logic [IDX_W-1:0] wdata,
  input  logic [ADR_W-1:0] norm_idx,
  input  logic [IDX_W-1:0] side_idx [2],
  output logic             bcast_ev,
  output logic             dn_valid,
  output logic [ADR_W-1:0] dn_addr,
  output logic [IDX_W-1:0] dn_data,
  output logic             tm_valid,
  output logic             tm_side,
  output logic [IDX_W-1:0] tm_reg,
  output logic [IDX_W-1:0] tm_data
);
  slot_t slot_q, pend_q, first_s, second_s, slot_d, pend_d;
  logic  pick;

  assign bcast_ev = data_ev && (mode == FM_PAIR) && both_bit;
  assign pick     = both_bit ? 1'b0 : bank_bit;

  always_comb begin
    if (mode == FM_PAIR) begin
      first_s  = pair_slot(pick, side_idx[pick], wdata);
      second_s = both_bit ? pair_slot(1'b1, side_idx[1], wdata) : SLOT_NONE;
    end else begin
      first_s  = plain_slot(norm_idx, wdata);
      second_s = SLOT_NONE;
    end
  end

  always_comb begin
    slot_d = SLOT_NONE;
    pend_d = SLOT_NONE;
    if (init_fire) begin
      slot_d = '{kind: SLOT_CHIP, side: 1'b1, addr: PAIR_INIT_ADR, val: PAIR_INIT_VAL};
    end else if (pend_q.kind != SLOT_IDLE) begin
      slot_d = pend_q;
    end else if (data_ev) begin
      slot_d = first_s;
      pend_d = second_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_NONE;
      pend_q <= SLOT_NONE;
    end else begin
      slot_q <= slot_d;
      pend_q <= pend_d;
    end
  end

  assign dn_valid = (slot_q.kind == SLOT_CHIP);
  assign dn_addr  = slot_q.addr;
  assign dn_data  = slot_q.val;
  assign tm_valid = (slot_q.kind == SLOT_TIMER);
  assign tm_side  = slot_q.side;
  assign tm_reg   = slot_q.addr[IDX_W-1:0];
  assign tm_data  = slot_q.val;
endmodule

// File: rtl/fm_port_frontend.sv
module fm_port_frontend
  import fm_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             host_wr,
  input  logic [OFS_W-1:0] host_ofs,
  input  logic [IDX_W-1:0] host_wdata,
  output logic [IDX_W-1:0] host_rdata,
  input  logic [IDX_W-1:0] tmr_stat0,
  input  logic [IDX_W-1:0] tmr_stat1,
  output logic             dn_wr_valid,
  output logic [ADR_W-1:0] dn_wr_addr,
  output logic [IDX_W-1:0] dn_wr_data,
  output logic             tmr_wr_valid,
  output logic             tmr_wr_side,
  output logic [IDX_W-1:0] tmr_wr_reg,
  output logic [IDX_W-1:0] tmr_wr_data,
  output logic [IDX_W-1:0] vol_left,
  output logic [IDX_W-1:0] vol_right
);
  fm_mode_e         mode;
  logic             init_pend, init_fire, host_go;
  logic             ctrl_active, ctrl_claim, addr_ev, data_ev, bcast_ev;
  logic [IDX_W-1:0] ctrl_rd;
  logic [ADR_W-1:0] norm_idx;
  logic [IDX_W-1:0] side_idx [2];

  assign mode = fm_mode_e'(mode_sel);

  // Named events for the checker.
  always_ff @(posedge clk) begin
    if (!rst_n) init_pend <= 1'b1;
    else        init_pend <= 1'b0;
  end
  assign init_fire = init_pend && (mode == FM_PAIR);
  assign host_go   = host_wr && !init_pend;
  assign addr_ev   = host_go && !host_ofs[0] && !ctrl_claim;
  assign data_ev   = host_go &&  host_ofs[0] && !ctrl_claim;

  fm_fe_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mode == FM_WIDE_CTL),
    .wr     (host_go),
    .ofs    (host_ofs),
    .wdata  (host_wdata),
    .active (ctrl_active),
    .claim  (ctrl_claim),
    .vol_l  (vol_left),
    .vol_r  (vol_right),
    .rd_val (ctrl_rd)
  );

  fm_fe_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .addr_ev  (addr_ev),
    .bank_bit (host_ofs[1]),
    .both_bit (host_ofs[3]),
    .wdata    (host_wdata),
    .norm_idx (norm_idx),
    .side_idx (side_idx)
  );

  fm_fe_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .init_fire (init_fire),
    .data_ev   (data_ev),
    .bank_bit  (host_ofs[1]),
    .both_bit  (host_ofs[3]),
    .wdata     (host_wdata),
    .norm_idx  (norm_idx),
    .side_idx  (side_idx),
    .bcast_ev  (bcast_ev),
    .dn_valid  (dn_wr_valid),
    .dn_addr   (dn_wr_addr),
    .dn_data   (dn_wr_data),
    .tm_valid  (tmr_wr_valid),
    .tm_side   (tmr_wr_side),
    .tm_reg    (tmr_wr_reg),
    .tm_data   (tmr_wr_data)
  );

  assign host_rdata = host_read(mode, host_ofs, ctrl_active, ctrl_rd, tmr_stat0, tmr_stat1);
endmodule

// File: rtl/fm_fe_checker.sv
module fm_fe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       host_wr,
  input logic [3:0] host_ofs,
  input logic [7:0] host_wdata,
  input logic       init_fire,
  input logic       bcast_ev,
  input logic       ctrl_active,
  input logic       dn_wr_valid,
  input logic [8:0] dn_wr_addr,
  input logic [7:0] dn_wr_data,
  input logic       tmr_wr_valid,
  input logic       tmr_wr_side,
  input logic [7:0] vol_left
);
  assert_one_sink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_wr_valid && tmr_wr_valid));

  assert_init_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (dn_wr_valid && dn_wr_addr == 9'h105 && dn_wr_data == 8'h01));

  assert_wave_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && dn_wr_valid && dn_wr_addr[7:0] >= 8'hE0) |-> (dn_wr_data[7:2] == 6'd0));

  assert_pan_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && dn_wr_valid && dn_wr_addr[7:0] >= 8'hC0 && dn_wr_addr[7:0] <= 8'hC8)
      |-> (dn_wr_data[7:4] == (dn_wr_addr[8] ? 4'hA : 4'h5)));

  assert_bcast_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_ev |=> ##1 ((!dn_wr_valid || dn_wr_addr[8]) && (!tmr_wr_valid || tmr_wr_side)));

  assert_ctl_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_active) |-> $past(host_wr && host_ofs == 4'h2 && host_wdata == 8'hFF));

  assert_vol_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_left) |-> $past(host_wr && host_ofs == 4'h3 && mode_sel == 2'd3));
endmodule

bind fm_port_frontend fm_fe_checker u_fm_fe_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .host_wr      (host_wr),
  .host_ofs     (host_ofs),
  .host_wdata   (host_wdata),
  .init_fire    (init_fire),
  .bcast_ev     (bcast_ev),
  .ctrl_active  (ctrl_active),
  .dn_wr_valid  (dn_wr_valid),
  .dn_wr_addr   (dn_wr_addr),
  .dn_wr_data   (dn_wr_data),
  .tmr_wr_valid (tmr_wr_valid),
  .tmr_wr_side  (tmr_wr_side),
  .vol_left     (vol_left)
);

// File: tb/test_fm_port_frontend.sv
module test_fm_port_frontend;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       host_wr = 1'b0;
  logic [3:0] host_ofs = 4'h0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] tmr_stat0 = 8'hC0;
  logic [7:0] tmr_stat1 = 8'h20;
  logic       dn_wr_valid, tmr_wr_valid, tmr_wr_side;
  logic [8:0] dn_wr_addr;
  logic [7:0] dn_wr_data, tmr_wr_reg, tmr_wr_data, vol_left, vol_right;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fm_port_frontend i_fm_port_frontend (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_wr(host_wr),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tmr_stat0(tmr_stat0), .tmr_stat1(tmr_stat1),
    .dn_wr_valid(dn_wr_valid), .dn_wr_addr(dn_wr_addr), .dn_wr_data(dn_wr_data),
    .tmr_wr_valid(tmr_wr_valid), .tmr_wr_side(tmr_wr_side),
    .tmr_wr_reg(tmr_wr_reg), .tmr_wr_data(tmr_wr_data),
    .vol_left(vol_left), .vol_right(vol_right)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic exp_dn(input string rq, input logic v, input logic [8:0] a, input logic [7:0] d);
    chk({rq, " dn valid"}, dn_wr_valid, v);
    chk({rq, " tmr idle"}, tmr_wr_valid, 1'b0);
    if (v) begin
      chk({rq, " dn addr"}, dn_wr_addr, a);
      chk({rq, " dn data"}, dn_wr_data, d);
    end
  endtask

  task automatic exp_tmr(input string rq, input logic s, input logic [7:0] r, input logic [7:0] d);
    chk({rq, " tmr valid"}, tmr_wr_valid, 1'b1);
    chk({rq, " dn idle"}, dn_wr_valid, 1'b0);
    chk({rq, " tmr side"}, tmr_wr_side, s);
    chk({rq, " tmr reg"}, tmr_wr_reg, r);
    chk({rq, " tmr data"}, tmr_wr_data, d);
  endtask

  // One-cycle host write; returns at the falling edge after the sampling edge.
  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    host_wr = 1'b1; host_ofs = o; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd(input string rq, input logic [3:0] o, input logic [7:0] exp);
    host_ofs = o;
    #1;
    chk(rq, host_rdata, exp);
  endtask

  // Reset in a mode; returns right before the first cycle after release.
  task automatic start(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; host_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    start(2'd3);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 dn quiet in reset", dn_wr_valid, 1'b0);
    chk("R1 tmr quiet in reset", tmr_wr_valid, 1'b0);
    chk("R1 vol_left reset", vol_left, 8'hFF);
    chk("R1 vol_right reset", vol_right, 8'hFF);
    rst_n = 1'b1;
    idle();
    rd("R1 window closed after reset", 4'h2, 8'hFF);
  endtask

  task automatic t_single();
    start(2'd0); idle();
    wr(4'h0, 8'h20); exp_dn("R2 addr write silent", 1'b0, 9'h0, 8'h0);
    wr(4'h1, 8'h5A); exp_dn("R2 data write", 1'b1, 9'h020, 8'h5A);
    idle();          exp_dn("R2 single pulse", 1'b0, 9'h0, 8'h0);
    wr(4'h2, 8'h40);
    wr(4'h3, 8'h07); exp_dn("R2 bit8 stays 0", 1'b1, 9'h040, 8'h07);
  endtask

  task automatic t_wide();
    start(2'd1); idle();
    wr(4'h2, 8'h20);
    wr(4'h3, 8'h11); exp_dn("R3 upper bank", 1'b1, 9'h120, 8'h11);
    wr(4'h0, 8'h20);
    wr(4'h1, 8'h22); exp_dn("R3 lower bank", 1'b1, 9'h020, 8'h22);
    wr(4'h2, 8'h05);
    wr(4'h3, 8'h01); exp_dn("R3 0x105 forwarded", 1'b1, 9'h105, 8'h01);
  endtask

  task automatic t_timer();
    start(2'd1); idle();
    wr(4'h0, 8'h04);
    wr(4'h1, 8'h80); exp_tmr("R4 timer ctl", 1'b0, 8'h04, 8'h80);
    wr(4'h2, 8'h02);
    wr(4'h3, 8'h33); exp_dn("R4 0x102 not timer", 1'b1, 9'h102, 8'h33);
    start(2'd2); idle();
    wr(4'h2, 8'h03);
    wr(4'h3, 8'h77); exp_tmr("R4 pair side1 timer", 1'b1, 8'h03, 8'h77);
  endtask

  task automatic t_pair();
    start(2'd2); idle();
    exp_dn("R9 pair init write", 1'b1, 9'h105, 8'h01);
    wr(4'h0, 8'hA0);
    wr(4'h2, 8'hA1);
    wr(4'h1, 8'h33); exp_dn("R5 side0", 1'b1, 9'h0A0, 8'h33);
    wr(4'h3, 8'h44); exp_dn("R5 side1 +0x100", 1'b1, 9'h1A1, 8'h44);
    wr(4'h8, 8'hB2);
    wr(4'h9, 8'h2C); exp_dn("R6 bcast first side0", 1'b1, 9'h0B2, 8'h2C);
    idle();          exp_dn("R6 bcast second side1", 1'b1, 9'h1B2, 8'h2C);
    idle();          exp_dn("R6 bcast ends", 1'b0, 9'h0, 8'h0);
    wr(4'h0, 8'h05);
    wr(4'h1, 8'hFF); exp_dn("R7 reg5 dropped", 1'b0, 9'h0, 8'h0);
    wr(4'h0, 8'hE3);
    wr(4'h1, 8'hFF); exp_dn("R7 waveform masked", 1'b1, 9'h0E3, 8'h03);
    wr(4'h2, 8'hC4);
    wr(4'h3, 8'h3B); exp_dn("R8 pan side1", 1'b1, 9'h1C4, 8'hAB);
    wr(4'h8, 8'hC8);
    wr(4'h9, 8'hF7); exp_dn("R8 pan side0 bcast", 1'b1, 9'h0C8, 8'h57);
    idle();          exp_dn("R8 pan side1 bcast", 1'b1, 9'h1C8, 8'hA7);
    wr(4'h0, 8'hC9);
    wr(4'h1, 8'hF7); exp_dn("R8 0xC9 untouched", 1'b1, 9'h0C9, 8'hF7);
  endtask

  task automatic t_init_ignore();
    start(2'd1);
    wr(4'h1, 8'h99); exp_dn("R9 first cycle write ignored", 1'b0, 9'h0, 8'h0);
    idle();          exp_dn("R9 nothing later", 1'b0, 9'h0, 8'h0);
  endtask

  task automatic t_ctrl();
    start(2'd3); idle();
    wr(4'h0, 8'h40);
    wr(4'h2, 8'hFF);
    rd("R11 status 0 when open", 4'h2, 8'h00);
    wr(4'h2, 8'h00); rd("R11 idx 0", 4'h3, 8'h70);
    wr(4'h2, 8'h15); rd("R11 idx 0x15", 4'h3, 8'h71);
    wr(4'h2, 8'h09);
    wr(4'h3, 8'h1F); exp_dn("R10 ctl data not forwarded", 1'b0, 9'h0, 8'h0);
    chk("R12 left volume", vol_left, 8'h1F);
    rd("R11 read left", 4'h3, 8'h1F);
    wr(4'h2, 8'h0A);
    wr(4'h3, 8'h22);
    chk("R12 right volume", vol_right, 8'h22);
    rd("R11 read right", 4'h3, 8'h22);
    wr(4'h2, 8'h07);
    wr(4'h3, 8'h55);
    chk("R12 other idx left same", vol_left, 8'h1F);
    chk("R12 other idx right same", vol_right, 8'h22);
    rd("R11 other idx", 4'h3, 8'hFF);
    wr(4'h2, 8'hFE);
    rd("R10 closed reads status path", 4'h2, 8'hFF);
    wr(4'h1, 8'h12); exp_dn("R10 chip index kept", 1'b1, 9'h040, 8'h12);
  endtask

  task automatic t_status();
    start(2'd0); idle();
    rd("R13 single even", 4'h0, 8'hC6);
    rd("R13 single other", 4'h1, 8'hFF);
    start(2'd1); idle();
    rd("R13 wide even", 4'h0, 8'hC0);
    rd("R13 wide other", 4'h2, 8'hFF);
    start(2'd2); idle();
    rd("R13 pair side0", 4'h0, 8'hC6);
    rd("R13 pair side1", 4'h2, 8'h26);
    rd("R13 pair odd", 4'h1, 8'hFF);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_wide();
    t_timer();
    t_pair();
    t_init_ignore();
    t_ctrl();
    t_status();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule